// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block watches the data side of a processor pipeline and flags any load or store whose bytes fall inside one of a small set of programmable watch regions. Each watch slot holds a base address and a control byte. The control byte arms the slot for reads, for writes, or for both. It also carries a compare mask that selects how many low address bits are ignored, so each slot covers an aligned power-of-two window of 1 to 64 bytes.

The hit flag is combinational from the access address and strobes. The pipeline can therefore stop the access in the same cycle, before memory is touched. Software programs the slots through two synchronous write ports that share one data bus, one for the base address and one for the control byte. A slot selector picks the slot being written. When several slots match, the lowest-numbered one is reported.

Top module: `dbm_matcher`

## Requirements
- R1: After reset every slot is disarmed, `bp_hit` is 0 and `bp_hit_idx` is 0.
- R2: Control byte layout: bit 7 arms writes, bit 6 arms reads, and bits 5:0 form the compare mask. A slot whose bits 7 and 6 are both 0 never hits.
- R3: A slot armed only for reads ignores write accesses, and a slot armed only for writes ignores read accesses.
- R4: A mask bit of 1 means the matching address bit is compared, and a 0 means it is ignored. Address bits 6 and above are always compared. A mask whose ones form an unbroken run from bit 5 downward, followed by z zeros, covers the aligned 2^z-byte window that contains the base address.
- R5: A mask with a 0 above a 1 is repaired: every bit below its highest zero is treated as ignored. For example, 0x2F behaves as 0x20 and covers a 32-byte window.
- R6: `bp_hit` and `bp_hit_idx` follow the access inputs in the same cycle, with no register on the path.
- R7: `acc_size` encodes a naturally aligned access of 1, 2, 4 or 8 bytes (codes 0 to 3). The access hits if any of its bytes lies in an armed window.
- R8: When more than one slot hits, `bp_hit_idx` reports the lowest slot index. With no hit, `bp_hit_idx` is 0.
- R9: A register write takes effect from the next cycle. An access in the same cycle as the write sees the old value. Writing a register with the value it already holds leaves matching unchanged.
- R10: With neither `acc_rd` nor `acc_wr` asserted, `bp_hit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_we | input | 1 | Write `cfg_wdata` into the selected slot's base address |
| cfg_ctrl_we | input | 1 | Write `cfg_wdata[7:0]` into the selected slot's control byte |
| cfg_sel | input | IDX_W | Slot written by the configuration ports |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_addr | input | ADDR_W | Address of the current data access |
| acc_size | input | 2 | log2 of access byte count |
| acc_rd | input | 1 | Current access is a load |
| acc_wr | input | 1 | Current access is a store |
| bp_hit | output | 1 | Some armed slot matches the access |
| bp_hit_idx | output | IDX_W | Lowest matching slot, 0 if none |

## Verification
The bench builds the block with its defaults: two slots and 32-bit addresses. With two slots it can place overlapping windows to exercise the lowest-index rule, and it can arm one slot per direction at the same time. The 32-bit address width lets windows sit right beside a 64-byte boundary, so bytes just outside each edge get probed. Masks are swept from one-byte windows up to full 64-byte windows, including broken masks. Multi-byte accesses are placed so that only an inner byte touches a window.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int CTRL_W  = 8;
    localparam int MASK_W  = 6;
    localparam int LD_BIT  = 6;
    localparam int ST_BIT  = 7;
    localparam int SIZE_W  = 2;

    typedef struct packed {
        logic              st_en;
        logic              ld_en;
        logic [MASK_W-1:0] cmp_mask;
    } slot_ctrl_t;

    typedef enum logic [SIZE_W-1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_B8 = 2'd3
    } acc_size_e;

    // Keep the run of ones from the top bit down; clear everything from
    // the first zero onward.
    function automatic logic [MASK_W-1:0] fix_mask(input logic [MASK_W-1:0] raw);
        logic [MASK_W-1:0] out;
        logic              run;
        run = 1'b1;
        for (int b = MASK_W - 1; b >= 0; b--) begin
            run    = run & raw[b];
            out[b] = run;
        end
        return out;
    endfunction

    function automatic slot_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        slot_ctrl_t c;
        c.st_en    = raw[ST_BIT];
        c.ld_en    = raw[LD_BIT];
        c.cmp_mask = fix_mask(raw[MASK_W-1:0]);
        return c;
    endfunction

endpackage

// File: rtl/dbm_slot.sv
module dbm_slot
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic              ctrl_we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] byte_ign,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic              hit
);
    localparam int HI_W = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] base_q;
    slot_ctrl_t        ctrl_q;
    logic [ADDR_W-1:0] cmp_full;
    logic              addr_eq;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (addr_we) base_q <= wdata;
            if (ctrl_we) ctrl_q <= decode_ctrl(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        cmp_full = {{HI_W{1'b1}}, ctrl_q.cmp_mask} & ~byte_ign;
        addr_eq  = ((acc_addr ^ base_q) & cmp_full) == '0;
        armed    = (acc_rd & ctrl_q.ld_en) | (acc_wr & ctrl_q.st_en);
        hit      = addr_eq & armed;
    end

endmodule

// File: rtl/dbm_pick.sv
module dbm_pick #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dbm_matcher.sv
module dbm_matcher
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_addr_we,
    input  logic              cfg_ctrl_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic              bp_hit,
    output logic [IDX_W-1:0]  bp_hit_idx
);
    logic [ADDR_W-1:0] byte_ign;
    logic [NUM_BP-1:0] slot_hit;

    // Offset bits inside a naturally aligned access never decide a match.
    always_comb begin
        byte_ign = (ADDR_W'(1) << acc_size) - ADDR_W'(1);
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        logic sel_me;
        assign sel_me = (cfg_sel == IDX_W'(g));
        dbm_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .addr_we  (cfg_addr_we & sel_me),
            .ctrl_we  (cfg_ctrl_we & sel_me),
            .wdata    (cfg_wdata),
            .acc_addr (acc_addr),
            .byte_ign (byte_ign),
            .acc_rd   (acc_rd),
            .acc_wr   (acc_wr),
            .hit      (slot_hit[g])
        );
    end

    dbm_pick #(.N(NUM_BP), .IDX_W(IDX_W)) u_pick (
        .req (slot_hit),
        .any (bp_hit),
        .idx (bp_hit_idx)
    );

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
    parameter int NUM_BP = 2,
    parameter int IDX_W  = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_rd,
    input logic             acc_wr,
    input logic             bp_hit,
    input logic [IDX_W-1:0] bp_hit_idx
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bp_hit);                                   // R1

    AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd || acc_wr) |-> !bp_hit);                          // R10

    AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bp_hit |-> bp_hit_idx == '0);                             // R8

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        bp_hit |-> int'(bp_hit_idx) < NUM_BP);                     // R8
endmodule

bind dbm_matcher dbm_checker #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_dbm_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .bp_hit     (bp_hit),
    .bp_hit_idx (bp_hit_idx)
);

// File: tb/tb_dbm_matcher.sv
module tb_dbm_matcher;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_addr_we, cfg_ctrl_we;
    logic [0:0]  cfg_sel;
    logic [31:0] cfg_wdata, acc_addr;
    logic [1:0]  acc_size;
    logic        acc_rd, acc_wr;
    logic        bp_hit;
    logic [0:0]  bp_hit_idx;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    bit [31:0] m_base [2];
    bit [7:0]  m_ctrl [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbm_matcher #(.ADDR_W(32), .NUM_BP(2)) dut (
        .clk(clk), .rst(rst),
        .cfg_addr_we(cfg_addr_we), .cfg_ctrl_we(cfg_ctrl_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .bp_hit(bp_hit), .bp_hit_idx(bp_hit_idx)
    );

    // Behavioural reference: window bounds and byte-by-byte overlap.
    function automatic void ref_match(input bit [31:0] a, input bit [1:0] sz,
                                      input bit rd, input bit wr,
                                      output bit h, output int idx);
        h = 0; idx = 0;
        for (int s = 0; s < 2; s++) begin
            int     lead;
            longint len, lo, n, first;
            bit     armed;
            armed = (rd && m_ctrl[s][6]) || (wr && m_ctrl[s][7]);
            lead = 0;
            for (int b = 5; b >= 0; b--) begin
                if (!m_ctrl[s][b]) break;
                lead++;
            end
            len   = longint'(1) << (6 - lead);
            lo    = longint'(m_base[s]) - (longint'(m_base[s]) % len);
            n     = longint'(1) << sz;
            first = longint'(a) - (longint'(a) % n);
            if (armed && !h) begin
                for (longint k = 0; k < n; k++) begin
                    if (first + k >= lo && first + k < lo + len) begin
                        h = 1; idx = s;
                    end
                end
            end
        end
    endfunction

    task automatic step(input bit aw, input bit cw, input bit sel, input bit [31:0] wd,
                        input bit [31:0] a, input bit [1:0] sz, input bit rd, input bit wr,
                        input string tag);
        bit e_hit; int e_idx;
        @(negedge clk);
        cfg_addr_we = aw; cfg_ctrl_we = cw; cfg_sel = sel; cfg_wdata = wd;
        acc_addr = a; acc_size = sz; acc_rd = rd; acc_wr = wr;
        #1;
        ref_match(a, sz, rd, wr, e_hit, e_idx);
        vectors++;
        if (bp_hit !== e_hit || (e_hit && int'(bp_hit_idx) != e_idx) ||
            (!e_hit && bp_hit_idx !== 1'b0)) begin
            errors++;
            $display("FAIL %s: addr=%h size=%0d rd=%0b wr=%0b got hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     tag, a, sz, rd, wr, bp_hit, bp_hit_idx, e_hit, e_idx);
        end
        @(posedge clk);
        if (aw) m_base[sel] = wd;
        if (cw) m_ctrl[sel] = wd[7:0];
    endtask

    task automatic wr_base(input bit sel, input bit [31:0] v);
        step(1, 0, sel, v, 32'h0, 0, 0, 0, "R9");
    endtask

    task automatic wr_ctrl(input bit sel, input bit [7:0] v);
        step(0, 1, sel, {24'h0, v}, 32'h0, 0, 0, 0, "R9");
    endtask

    task automatic rd(input bit [31:0] a, input bit [1:0] sz, input string tag);
        step(0, 0, 0, 0, a, sz, 1, 0, tag);
    endtask

    task automatic wrt(input bit [31:0] a, input bit [1:0] sz, input string tag);
        step(0, 0, 0, 0, a, sz, 0, 1, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1;
        cfg_addr_we = 0; cfg_ctrl_we = 0; cfg_sel = 0; cfg_wdata = 0;
        acc_addr = 0; acc_size = 0; acc_rd = 0; acc_wr = 0;
        m_base[0] = 0; m_base[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: disarmed after reset, even with strobes and address 0
        rd(32'h0, 0, "R1");
        wrt(32'h0, 3, "R1");

        // R4: slot 0 reads only, mask 0x3C -> 4-byte window 0x1000_0040..43
        wr_base(0, 32'h1000_0041);
        wr_ctrl(0, 8'h7C);
        rd(32'h1000_003F, 0, "R4");
        rd(32'h1000_0040, 0, "R4");
        rd(32'h1000_0043, 0, "R4");
        rd(32'h1000_0044, 0, "R4");
        rd(32'h1000_0041, 2'(32'h0), "R6");
        // R3: write to the same byte is ignored by a read-only slot
        wrt(32'h1000_0040, 0, "R3");
        // R10: no strobes
        step(0, 0, 0, 0, 32'h1000_0040, 0, 0, 0, "R10");

        // R5: slot 1 writes only, mask 0x2F repaired to 0x20 -> 32 bytes
        wr_base(1, 32'h2000_0010);
        wr_ctrl(1, 8'hAF);
        wrt(32'h1FFF_FFFF, 0, "R5");
        wrt(32'h2000_0000, 0, "R5");
        wrt(32'h2000_001F, 0, "R5");
        wrt(32'h2000_0020, 0, "R5");
        rd(32'h2000_0010, 0, "R3");

        // R8: slot 1 both directions, mask 0 -> 64 bytes over 0x1000_0040..7F
        wr_base(1, 32'h1000_0070);
        wr_ctrl(1, 8'hC0);
        rd(32'h1000_0040, 0, "R8");
        rd(32'h1000_0050, 0, "R8");
        wrt(32'h1000_0042, 1, "R8");
        rd(32'h1000_0080, 0, "R4");
        rd(32'h1000_003F, 0, "R4");

        // R7: slot 0 one byte at 0x3000_0006, both directions
        wr_base(0, 32'h3000_0006);
        wr_ctrl(0, 8'hFF);
        rd(32'h3000_0004, 2, "R7");
        rd(32'h3000_0004, 1, "R7");
        rd(32'h3000_0006, 1, "R7");
        wrt(32'h3000_0000, 3, "R7");
        wrt(32'h3000_0008, 2, "R7");
        rd(32'h3000_0007, 0, "R7");

        // R9: access in the write cycle sees the old value; same-value rewrite
        step(0, 1, 0, 32'h0000_0000, 32'h3000_0006, 0, 1, 0, "R9");
        rd(32'h3000_0006, 0, "R2");
        step(0, 1, 0, 32'h0000_00FF, 32'h3000_0006, 0, 1, 0, "R9");
        step(0, 1, 0, 32'h0000_00FF, 32'h3000_0006, 0, 1, 0, "R9");
        rd(32'h3000_0006, 0, "R9");
        step(1, 0, 0, 32'h3000_0100, 32'h3000_0006, 0, 1, 0, "R9");
        rd(32'h3000_0006, 0, "R9");
        rd(32'h3000_0100, 0, "R9");

        // R2: both enable bits clear with a full mask never hits
        wr_ctrl(1, 8'h3F);
        wr_ctrl(0, 8'h00);
        rd(32'h1000_0070, 0, "R2");
        wrt(32'h3000_0100, 0, "R2");

        // Mixed sweep against the reference
        for (int i = 0; i < 400; i++) begin
            bit [31:0] a;
            bit [1:0]  sz;
            bit        s;
            s  = 1'($urandom);
            sz = 2'($urandom);
            a  = 32'h4000_0000 | 32'($urandom_range(0, 255));
            a  = a & ~((32'h1 << sz) - 32'h1);
            if (i % 25 == 0) step(1, 0, s, 32'h4000_0000 | 32'($urandom_range(0, 255)),
                                  a, sz, 1, 0, "R9");
            else if (i % 25 == 1) step(0, 1, s, 32'($urandom_range(0, 255)), a, sz, 0, 1, "R5");
            else step(0, 0, 0, 0, a, sz, 1'($urandom), 1'($urandom), "R4");
        end

        finish_run();
    end
endmodule